// File: doc/BRIEF.md
# SPI Host Register File with Byte FIFOs

This block is the register side of an SPI host controller. A processor reaches it through a simple word bus: a byte address, a write enable with 32-bit write data, and a read strobe. During a read strobe the block returns read data in the same cycle. Behind the bus sit two 8-entry byte queues. The transmit queue takes bytes written by software and hands them to a serial engine through a valid/pop handshake. The receive queue takes bytes the engine pushes back and hands them to software when it reads the receive data word. The block also holds the static configuration that the engine consumes: clock divide, clock mode, chip-select id, default and mode, two delay words and the frame format.

The status of each queue is folded into bit 31 of its data word, so software needs no separate status register. A transmit watermark interrupt is raised while the transmit queue holds strictly fewer bytes than its mark. A receive watermark interrupt is raised while the receive queue holds strictly more bytes than its mark. Both pending flags come straight from the live queue counts. An enable mask gates them onto one level-sensitive interrupt line.

Top module: `spi_host_regs`

## Requirements
- R1: After reset the clock divide word (0x00) reads 0x3, delay word 0 (0x28) reads 0x1001 and delay word 1 (0x2C) reads 0x1. All other registers read 0, both queues are empty, so a read of 0x4C returns 0x80000000, and the interrupt is low.
- R2: A write to 0x48 pushes bits [7:0] of the write data into the transmit queue. The engine sees the oldest byte on tx_byte while tx_valid is high, and each tx_pop cycle removes it, in first-in first-out order.
- R3: A read of 0x48 returns 0x80000000 while the transmit queue holds 8 bytes and 0 otherwise. A write to 0x48 while the queue is full is dropped.
- R4: A read of 0x4C while the receive queue is empty returns 0x80000000 and removes nothing. Otherwise it returns the oldest byte in bits [7:0], with bit 31 clear, and removes that byte. An rx_push while the receive queue is full is dropped.
- R5: Bit 0 of the pending word (0x74) is 1 exactly when the transmit queue count is strictly less than the transmit mark (0x50).
- R6: Bit 1 of the pending word is 1 exactly when the receive queue count is strictly greater than the receive mark (0x54).
- R7: irq is high exactly when the pending word ANDed with the enable word (0x70) is nonzero. Enable bit 0 gates the transmit watermark and enable bit 1 gates the receive watermark.
- R8: A write of a value of 8 or more to 0x50 or 0x54 is ignored and the old mark is kept.
- R9: Writes to 0x4C, 0x74, 0x60 and 0x64 change nothing. The words at 0x60 and 0x64 always read 0.
- R10: Reserved offsets (0x08, 0x0C, 0x1C, 0x20, 0x24, 0x30 to 0x3C, 0x44, 0x58, 0x5C, 0x68, 0x6C) and offsets from 0x78 upward ignore writes and read 0.
- R11: The configuration words at 0x00, 0x04, 0x10, 0x14, 0x18, 0x28, 0x2C and 0x40 store all 32 bits written, read them back, and drive the matching cfg_ output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address; bits [1:0] are ignored |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; a read of 0x4C pops at the clock edge |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| tx_valid | output | 1 | Transmit queue holds at least one byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_pop | input | 1 | Engine takes the oldest transmit byte |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| irq | output | 1 | Level interrupt |
| cfg_sck_div | output | 32 | Clock divide word |
| cfg_sck_mode | output | 32 | Clock mode word |
| cfg_cs_id | output | 32 | Chip-select id word |
| cfg_cs_def | output | 32 | Chip-select default word |
| cfg_cs_mode | output | 32 | Chip-select mode word |
| cfg_delay0 | output | 32 | Delay word 0 |
| cfg_delay1 | output | 32 | Delay word 1 |
| cfg_frame | output | 32 | Frame format word |

## Verification
Some properties are checked on every cycle. These are: queue counts never pass the depth, pushes into a full queue and pops from an empty one leave the count alone, stored marks stay below the depth, an empty receive queue never raises the receive watermark, a zero enable mask keeps the interrupt low, and an empty receive read returns the empty flag. Other behaviour needs the bench's scenarios. These are: first-in first-out byte order through both queues, reset values, the exact crossing points of the two strict watermark comparisons, and the fact that writes to read-only, flash and reserved words leave all visible state unchanged.

// File: rtl/spi_host_regs_pkg.sv
package spi_host_regs_pkg;

    localparam int BUS_AW  = 8;
    localparam int WORD_W  = BUS_AW - 2;
    localparam int DATA_W  = 32;
    localparam int BYTE_W  = 8;

    // word indices (byte offset / 4)
    localparam logic [WORD_W-1:0] W_SCK_DIV  = 6'h00;
    localparam logic [WORD_W-1:0] W_SCK_MODE = 6'h01;
    localparam logic [WORD_W-1:0] W_CS_ID    = 6'h04;
    localparam logic [WORD_W-1:0] W_CS_DEF   = 6'h05;
    localparam logic [WORD_W-1:0] W_CS_MODE  = 6'h06;
    localparam logic [WORD_W-1:0] W_DELAY0   = 6'h0A;
    localparam logic [WORD_W-1:0] W_DELAY1   = 6'h0B;
    localparam logic [WORD_W-1:0] W_FRAME    = 6'h10;
    localparam logic [WORD_W-1:0] W_TX_DATA  = 6'h12;
    localparam logic [WORD_W-1:0] W_RX_DATA  = 6'h13;
    localparam logic [WORD_W-1:0] W_TX_MARK  = 6'h14;
    localparam logic [WORD_W-1:0] W_RX_MARK  = 6'h15;
    localparam logic [WORD_W-1:0] W_FL_CTRL  = 6'h18;
    localparam logic [WORD_W-1:0] W_FL_FMT   = 6'h19;
    localparam logic [WORD_W-1:0] W_IRQ_EN   = 6'h1C;
    localparam logic [WORD_W-1:0] W_IRQ_PEND = 6'h1D;

    localparam logic [DATA_W-1:0] STATUS_FLAG = 32'h8000_0000;

    typedef struct packed {
        logic [DATA_W-1:0] sck_div;
        logic [DATA_W-1:0] sck_mode;
        logic [DATA_W-1:0] cs_id;
        logic [DATA_W-1:0] cs_def;
        logic [DATA_W-1:0] cs_mode;
        logic [DATA_W-1:0] delay0;
        logic [DATA_W-1:0] delay1;
        logic [DATA_W-1:0] frame;
        logic [DATA_W-1:0] tx_mark;
        logic [DATA_W-1:0] rx_mark;
        logic [DATA_W-1:0] irq_en;
    } cfg_regs_t;

    localparam cfg_regs_t CFG_RESET = '{
        sck_div:  32'h3,
        sck_mode: 32'h0,
        cs_id:    32'h0,
        cs_def:   32'h0,
        cs_mode:  32'h0,
        delay0:   32'h1001,
        delay1:   32'h1,
        frame:    32'h0,
        tx_mark:  32'h0,
        rx_mark:  32'h0,
        irq_en:   32'h0
    };

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign count   = st_q.cnt;
    assign dout    = st_q.mem[st_q.rd];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr           = ptr_inc(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: occupancy never exceeds the depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R3 / R4: push into a full queue without a pop is dropped
    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (st_q.cnt == $past(st_q.cnt)));

    // R4: pop of an empty queue without a push leaves it empty
    a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/spi_wmark_irq.sv
module spi_wmark_irq #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] tx_mark,
    input  logic [CNT_W-1:0] rx_mark,
    input  logic [1:0]       irq_en,
    output logic [1:0]       pend,
    output logic             irq
);

    always_comb begin
        pend[0] = (tx_cnt < tx_mark);
        pend[1] = (rx_cnt > rx_mark);
        irq     = |(pend & irq_en);
    end

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_regs_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              irq,
    output logic [DATA_W-1:0] cfg_sck_div,
    output logic [DATA_W-1:0] cfg_sck_mode,
    output logic [DATA_W-1:0] cfg_cs_id,
    output logic [DATA_W-1:0] cfg_cs_def,
    output logic [DATA_W-1:0] cfg_cs_mode,
    output logic [DATA_W-1:0] cfg_delay0,
    output logic [DATA_W-1:0] cfg_delay1,
    output logic [DATA_W-1:0] cfg_frame
);

    cfg_regs_t         regs_d, regs_q;
    logic [WORD_W-1:0] word;
    logic              tx_push, tx_full, tx_empty;
    logic              rx_pop, rx_full, rx_empty;
    logic [BYTE_W-1:0] rx_head;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic [1:0]        pend;

    assign word    = bus_addr[BUS_AW-1:2];
    assign tx_push = bus_we && (word == W_TX_DATA);
    assign rx_pop  = bus_re && (word == W_RX_DATA);

    spi_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_tx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .din   (bus_wdata[BYTE_W-1:0]),
        .pop   (tx_pop),
        .dout  (tx_byte),
        .full  (tx_full),
        .empty (tx_empty),
        .count (tx_cnt)
    );

    spi_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_rx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   (rx_byte),
        .pop   (rx_pop),
        .dout  (rx_head),
        .full  (rx_full),
        .empty (rx_empty),
        .count (rx_cnt)
    );

    spi_wmark_irq #(.CNT_W(CNT_W)) u_irq (
        .tx_cnt  (tx_cnt),
        .rx_cnt  (rx_cnt),
        .tx_mark (regs_q.tx_mark[CNT_W-1:0]),
        .rx_mark (regs_q.rx_mark[CNT_W-1:0]),
        .irq_en  (regs_q.irq_en[1:0]),
        .pend    (pend),
        .irq     (irq)
    );

    assign tx_valid = !tx_empty;

    // register write decode
    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            case (word)
                W_SCK_DIV:  regs_d.sck_div  = bus_wdata;
                W_SCK_MODE: regs_d.sck_mode = bus_wdata;
                W_CS_ID:    regs_d.cs_id    = bus_wdata;
                W_CS_DEF:   regs_d.cs_def   = bus_wdata;
                W_CS_MODE:  regs_d.cs_mode  = bus_wdata;
                W_DELAY0:   regs_d.delay0   = bus_wdata;
                W_DELAY1:   regs_d.delay1   = bus_wdata;
                W_FRAME:    regs_d.frame    = bus_wdata;
                W_IRQ_EN:   regs_d.irq_en   = bus_wdata;
                W_TX_MARK: if (bus_wdata < DATA_W'(DEPTH)) regs_d.tx_mark = bus_wdata;
                W_RX_MARK: if (bus_wdata < DATA_W'(DEPTH)) regs_d.rx_mark = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= CFG_RESET;
        else        regs_q <= regs_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (word)
            W_SCK_DIV:  bus_rdata = regs_q.sck_div;
            W_SCK_MODE: bus_rdata = regs_q.sck_mode;
            W_CS_ID:    bus_rdata = regs_q.cs_id;
            W_CS_DEF:   bus_rdata = regs_q.cs_def;
            W_CS_MODE:  bus_rdata = regs_q.cs_mode;
            W_DELAY0:   bus_rdata = regs_q.delay0;
            W_DELAY1:   bus_rdata = regs_q.delay1;
            W_FRAME:    bus_rdata = regs_q.frame;
            W_TX_MARK:  bus_rdata = regs_q.tx_mark;
            W_RX_MARK:  bus_rdata = regs_q.rx_mark;
            W_IRQ_EN:   bus_rdata = regs_q.irq_en;
            W_IRQ_PEND: bus_rdata = {{(DATA_W-2){1'b0}}, pend};
            W_TX_DATA:  bus_rdata = tx_full ? STATUS_FLAG : '0;
            W_RX_DATA:  bus_rdata = rx_empty ? STATUS_FLAG
                                             : {{(DATA_W-BYTE_W){1'b0}}, rx_head};
            default:    bus_rdata = '0;
        endcase
    end

    assign cfg_sck_div  = regs_q.sck_div;
    assign cfg_sck_mode = regs_q.sck_mode;
    assign cfg_cs_id    = regs_q.cs_id;
    assign cfg_cs_def   = regs_q.cs_def;
    assign cfg_cs_mode  = regs_q.cs_mode;
    assign cfg_delay0   = regs_q.delay0;
    assign cfg_delay1   = regs_q.delay1;
    assign cfg_frame    = regs_q.frame;

    // R8: stored marks always stay below the depth
    a_r8_mark_range: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.tx_mark < DATA_W'(DEPTH)) && (regs_q.rx_mark < DATA_W'(DEPTH)));

    // R6: an empty receive queue never raises the receive watermark
    a_r6_empty_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> !pend[1]);

    // R7: a zero enable mask keeps the line low
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.irq_en[1:0] == 2'b00) |-> !irq);

    // R4: empty receive read returns only the status flag
    a_r4_rd_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |-> (bus_rdata == STATUS_FLAG));

endmodule

// File: tb/sim_spi_host_regs.sv
module sim_spi_host_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_pop = 1'b0;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        irq;
    logic [31:0] cfg_sck_div, cfg_sck_mode, cfg_cs_id, cfg_cs_def;
    logic [31:0] cfg_cs_mode, cfg_delay0, cfg_delay1, cfg_frame;

    int checks = 0;
    int fails  = 0;

    logic [31:0] rd_exp_q[$];
    string       rd_tag_q[$];
    logic [7:0]  tx_exp_q[$];

    always #5 clk = ~clk;

    spi_host_regs u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_re(bus_re), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte), .irq(irq),
        .cfg_sck_div(cfg_sck_div), .cfg_sck_mode(cfg_sck_mode),
        .cfg_cs_id(cfg_cs_id), .cfg_cs_def(cfg_cs_def),
        .cfg_cs_mode(cfg_cs_mode), .cfg_delay0(cfg_delay0),
        .cfg_delay1(cfg_delay1), .cfg_frame(cfg_frame)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: compares read data and engine bytes against the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_re) begin
            if (rd_exp_q.size() == 0) begin
                chk(1'b0, "unexpected read", bus_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = rd_exp_q.pop_front();
                t = rd_tag_q.pop_front();
                chk(bus_rdata == e, t, bus_rdata, e);
            end
        end
        if (rst_n && tx_pop) begin
            if (tx_exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected pop", {24'h0, tx_byte}, 32'h0);
            end else begin
                logic [7:0] b;
                b = tx_exp_q.pop_front();
                chk(tx_byte == b, "R2 tx byte order", {24'h0, tx_byte}, {24'h0, b});
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        rd_exp_q.push_back(e);
        rd_tag_q.push_back(t);
        @(posedge clk); #1;
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic eng_pop(input logic [7:0] e);
        chk(tx_valid == 1'b1, "R2 tx_valid before pop", {31'h0, tx_valid}, 32'h1);
        tx_exp_q.push_back(e);
        @(posedge clk); #1;
        tx_pop = 1'b1;
        @(posedge clk); #1;
        tx_pop = 1'b0;
    endtask

    task automatic eng_push(input logic [7:0] b);
        @(posedge clk); #1;
        rx_push = 1'b1; rx_byte = b;
        @(posedge clk); #1;
        rx_push = 1'b0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(8'h00, 32'h3, "R1 clock divide reset");
        rd(8'h28, 32'h1001, "R1 delay0 reset");
        rd(8'h2C, 32'h1, "R1 delay1 reset");
        rd(8'h04, 32'h0, "R1 clock mode reset");
        rd(8'h74, 32'h0, "R1 pending reset");
        rd(8'h48, 32'h0, "R1 tx not full");
        rd(8'h4C, 32'h8000_0000, "R1 rx empty");
        chk(irq == 1'b0, "R1 irq low", {31'h0, irq}, 32'h0);
        chk(tx_valid == 1'b0, "R1 tx queue empty", {31'h0, tx_valid}, 32'h0);

        // R11: configuration words
        wr(8'h00, 32'h0000_1234);
        rd(8'h00, 32'h0000_1234, "R11 clock divide readback");
        chk(cfg_sck_div == 32'h1234, "R11 cfg_sck_div", cfg_sck_div, 32'h1234);
        wr(8'h40, 32'h8000_0005);
        rd(8'h40, 32'h8000_0005, "R11 frame readback");
        chk(cfg_frame == 32'h8000_0005, "R11 cfg_frame", cfg_frame, 32'h8000_0005);
        wr(8'h14, 32'h3);
        chk(cfg_cs_def == 32'h3, "R11 cfg_cs_def", cfg_cs_def, 32'h3);

        // R10: reserved and out-of-range offsets
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h0, "R10 reserved 0x08");
        wr(8'h30, 32'hA5A5_A5A5);
        rd(8'h30, 32'h0, "R10 reserved 0x30");
        rd(8'h7C, 32'h0, "R10 beyond map");
        chk(cfg_sck_div == 32'h1234, "R10 no side effect", cfg_sck_div, 32'h1234);

        // R2 / R3: fill transmit queue
        for (int i = 0; i < 7; i++) wr(8'h48, 32'h100 | (32'hA0 + i));
        rd(8'h48, 32'h0, "R3 seven bytes not full");
        wr(8'h48, 32'hA7);
        rd(8'h48, 32'h8000_0000, "R3 eight bytes full");
        wr(8'h48, 32'hEE);
        for (int i = 0; i < 8; i++) eng_pop(8'hA0 + 8'(i));
        chk(tx_valid == 1'b0, "R3 ninth byte dropped", {31'h0, tx_valid}, 32'h0);
        rd(8'h48, 32'h0, "R3 not full after drain");

        // R5 / R7 / R8: transmit watermark
        wr(8'h50, 32'h4);
        rd(8'h50, 32'h4, "R8 tx mark stored");
        rd(8'h74, 32'h1, "R5 empty below mark");
        chk(irq == 1'b0, "R7 disabled", {31'h0, irq}, 32'h0);
        wr(8'h70, 32'h1);
        chk(irq == 1'b1, "R7 tx enabled", {31'h0, irq}, 32'h1);
        wr(8'h50, 32'h9);
        rd(8'h50, 32'h4, "R8 mark write of 9 ignored");
        wr(8'h54, 32'h8);
        rd(8'h54, 32'h0, "R8 mark write of 8 ignored");
        for (int i = 0; i < 4; i++) wr(8'h48, 32'h11 + i);
        rd(8'h74, 32'h0, "R5 count equal to mark");
        chk(irq == 1'b0, "R7 no pending", {31'h0, irq}, 32'h0);
        eng_pop(8'h11);
        chk(irq == 1'b1, "R5 count below mark after pop", {31'h0, irq}, 32'h1);
        eng_pop(8'h12); eng_pop(8'h13); eng_pop(8'h14);
        wr(8'h70, 32'h0);

        // R6 / R4: receive watermark and order
        wr(8'h54, 32'h2);
        wr(8'h70, 32'h2);
        eng_push(8'h31); eng_push(8'h32);
        rd(8'h74, 32'h1, "R6 count equal to mark");
        chk(irq == 1'b0, "R7 rx not above mark", {31'h0, irq}, 32'h0);
        eng_push(8'h33);
        rd(8'h74, 32'h3, "R6 count above mark");
        chk(irq == 1'b1, "R7 rx enabled", {31'h0, irq}, 32'h1);
        rd(8'h4C, 32'h31, "R4 first rx byte");
        rd(8'h74, 32'h1, "R6 back to mark");
        chk(irq == 1'b0, "R7 rx cleared", {31'h0, irq}, 32'h0);
        rd(8'h4C, 32'h32, "R4 second rx byte");
        rd(8'h4C, 32'h33, "R4 third rx byte");
        rd(8'h4C, 32'h8000_0000, "R4 empty after drain");

        // R4: overfill receive queue
        for (int i = 0; i < 9; i++) eng_push(8'h40 + 8'(i));
        for (int i = 0; i < 8; i++) rd(8'h4C, 32'h40 + i, "R4 rx order full");
        rd(8'h4C, 32'h8000_0000, "R4 ninth push dropped");

        // R9: writes with no effect
        eng_push(8'h55);
        wr(8'h4C, 32'hFF);
        wr(8'h74, 32'h0);
        wr(8'h60, 32'hF);
        wr(8'h64, 32'hF);
        rd(8'h60, 32'h0, "R9 flash control reads 0");
        rd(8'h64, 32'h0, "R9 flash format reads 0");
        rd(8'h74, 32'h1, "R9 pending unchanged");
        rd(8'h4C, 32'h55, "R9 rx queue unchanged");
        rd(8'h4C, 32'h8000_0000, "R9 rx empty again");

        repeat (3) @(posedge clk);
        chk(rd_exp_q.size() == 0, "scoreboard drained", rd_exp_q.size(), 0);
        chk(tx_exp_q.size() == 0, "R2 engine scoreboard drained", tx_exp_q.size(), 0);
        summary();
    end

endmodule